// File: doc/BRIEF.md
# GPIO Pin and Pattern Interrupt Unit

This block turns activity on a 32-bit bus of general-purpose input pins into interrupt requests. Eight pin channels each watch one pin, picked through a select field. A channel reports either edges, which are latched until software clears them, or levels, which are reported only while the level is present. Two group engines watch a masked set of pins and compare each pin against a per-pin polarity. They fire when every enabled pin agrees (AND) or when any enabled pin agrees (OR). They can report either the live match or a latched flag raised when the match begins.

Pins pass through a two-flop synchroniser before any detection. Software reaches configuration and status through a single-cycle write port and a combinational read port. Status bits are cleared by writing ones. The request outputs go to the processor's interrupt controller.

Top module: `gpio_irq_unit`

## Requirements
- R1: After reset all request outputs are low, and every register reads zero. Channels are therefore disabled, and group masks are empty.
- R2: Channel k (k = 0..7) is configured at address k. Bits [4:0] select any of the 32 pins, bit 8 selects the mode (0 = edge, 1 = level), bit 9 enables rising edge or high level, and bit 10 enables falling edge or low level.
- R3: In edge mode, an enabled rising edge sets the channel's status bit. That bit is output on `chan_irq_o[k]`, is readable as bit k at address 8, and stays set after the pin returns until a 1 is written to bit k at address 8.
- R4: In edge mode, an enabled falling edge sets the status bit. An edge whose direction is not enabled has no effect.
- R5: In level mode, `chan_irq_o[k]` is high exactly while the selected pin is at an enabled level (high with bit 9, low with bit 10). Nothing is latched.
- R6: Any write to a channel's configuration address clears that channel's pending edge status in the same cycle.
- R7: Writing 0 to a status bit leaves that bit unchanged.
- R8: Group j (j = 0, 1) has a control register at address 9+3j, a mask at 10+3j and a polarity at 11+3j. Control bit 0 = 1 selects AND mode, which matches when every masked pin equals its polarity bit. An empty mask never matches.
- R9: With control bit 0 = 0 (OR mode), the group matches when at least one masked pin equals its polarity bit.
- R10: Control bit 1 selects edge reporting. A flag is raised on the transition into the match, stays set after the match ends, shows on `grp_irq_o[j]` and bit j of address 15, and is cleared by writing 1 to bit j of address 15. With bit 1 = 0, `grp_irq_o[j]` is the live match.
- R11: A pin change reaches a level-type output after exactly two rising clock edges. When pins and register writes stay quiet for four cycles, all request outputs hold constant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pins_i | input | 32 | Asynchronous general-purpose pin inputs |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address for read and write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| chan_irq_o | output | 8 | Per-channel interrupt requests |
| grp_irq_o | output | 2 | Per-group interrupt requests |

## Verification
The properties assume that pin changes take effect only after the synchroniser. They treat a window of four cycles with constant pins and no register write as a settled state, in which outputs must hold and a write-one-to-clear must succeed. The checker learns each channel's mode and each group's reporting style only by watching writes on the register port. The stimulus changes pins one step at a time, always on the falling clock edge, and waits at least six cycles before comparing. It never changes a pin in the same cycle as a clear it wants to see succeed.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

    localparam int SEL_W       = 5;
    localparam int CFG_LVL_BIT = 8;
    localparam int CFG_HI_BIT  = 9;
    localparam int CFG_LO_BIT  = 10;
    localparam int GCTL_AND    = 0;
    localparam int GCTL_EDGE   = 1;

    typedef struct packed {
        logic [SEL_W-1:0] sel;
        logic             level;
        logic             en_hi;
        logic             en_lo;
    } chan_cfg_t;

    typedef struct packed {
        logic and_mode;
        logic edge_mode;
    } grp_ctl_t;

    function automatic chan_cfg_t word_to_cfg(input logic [31:0] w);
        chan_cfg_t c;
        c.sel   = w[SEL_W-1:0];
        c.level = w[CFG_LVL_BIT];
        c.en_hi = w[CFG_HI_BIT];
        c.en_lo = w[CFG_LO_BIT];
        return c;
    endfunction

    function automatic logic [31:0] cfg_to_word(input chan_cfg_t c);
        logic [31:0] w;
        w              = '0;
        w[SEL_W-1:0]   = c.sel;
        w[CFG_LVL_BIT] = c.level;
        w[CFG_HI_BIT]  = c.en_hi;
        w[CFG_LO_BIT]  = c.en_lo;
        return w;
    endfunction

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] raw_i,
    output logic [W-1:0] cur_o,
    output logic [W-1:0] prev_o
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
        logic [W-1:0] prev;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d.s1   = raw_i;
        st_d.s2   = st_q.s1;
        st_d.prev = st_q.s2;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cur_o  = st_q.s2;
    assign prev_o = st_q.prev;
endmodule

// File: rtl/gpio_pin_chan.sv
module gpio_pin_chan
    import gpio_irq_pkg::*;
#(
    parameter int NPINS = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPINS-1:0] cur_i,
    input  logic [NPINS-1:0] prev_i,
    input  chan_cfg_t        cfg_i,
    input  logic             cfg_wr_i,
    input  logic             clr_i,
    output logic             irq_o
);
    logic pend_d, pend_q;
    logic pin_now, pin_old, hit, lvl_req;

    always_comb begin
        pin_now = cur_i[cfg_i.sel];
        pin_old = prev_i[cfg_i.sel];
        hit     = (cfg_i.en_hi & pin_now & ~pin_old) |
                  (cfg_i.en_lo & ~pin_now & pin_old);
        lvl_req = (cfg_i.en_hi & pin_now) | (cfg_i.en_lo & ~pin_now);
        if (cfg_wr_i) pend_d = 1'b0;
        else          pend_d = (pend_q & ~clr_i) | (hit & ~cfg_i.level);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pend_q <= 1'b0;
        else        pend_q <= pend_d;
    end

    assign irq_o = cfg_i.level ? lvl_req : pend_q;
endmodule

// File: rtl/gpio_grp_match.sv
module gpio_grp_match
    import gpio_irq_pkg::*;
#(
    parameter int NPINS = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPINS-1:0] cur_i,
    input  logic [NPINS-1:0] mask_i,
    input  logic [NPINS-1:0] pol_i,
    input  grp_ctl_t         ctl_i,
    input  logic             clr_i,
    output logic             irq_o
);
    typedef struct packed {
        logic match;
        logic flag;
    } grp_st_t;

    grp_st_t st_d, st_q;
    logic [NPINS-1:0] agree;
    logic all_ok, any_ok, match;

    always_comb begin
        agree  = ~(cur_i ^ pol_i);
        all_ok = (|mask_i) & (&(agree | ~mask_i));
        any_ok = |(agree & mask_i);
        match  = ctl_i.and_mode ? all_ok : any_ok;
        st_d.match = match;
        st_d.flag  = (st_q.flag & ~clr_i) | (ctl_i.edge_mode & match & ~st_q.match);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign irq_o = ctl_i.edge_mode ? st_q.flag : match;
endmodule

// File: rtl/gpio_irq_unit.sv
module gpio_irq_unit
    import gpio_irq_pkg::*;
#(
    parameter int NPINS  = 32,
    parameter int NCHAN  = 8,
    parameter int NGRP   = 2,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NPINS-1:0]  pins_i,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic [NCHAN-1:0]  chan_irq_o,
    output logic [NGRP-1:0]   grp_irq_o
);
    localparam int STAT_ADDR  = NCHAN;
    localparam int GRP_BASE   = NCHAN + 1;
    localparam int GSTAT_ADDR = GRP_BASE + 3 * NGRP;

    typedef struct packed {
        chan_cfg_t [NCHAN-1:0]           ccfg;
        grp_ctl_t  [NGRP-1:0]            gctl;
        logic      [NGRP-1:0][NPINS-1:0] gmask;
        logic      [NGRP-1:0][NPINS-1:0] gpol;
    } regs_t;

    regs_t            st_d, st_q;
    logic [NCHAN-1:0] cfg_wr, chan_clr;
    logic [NGRP-1:0]  grp_clr;
    logic [NPINS-1:0] pin_cur, pin_prev;

    always_comb begin
        st_d     = st_q;
        cfg_wr   = '0;
        chan_clr = '0;
        grp_clr  = '0;
        if (reg_we) begin
            for (int k = 0; k < NCHAN; k++) begin
                if (reg_addr == ADDR_W'(k)) begin
                    st_d.ccfg[k] = word_to_cfg(reg_wdata);
                    cfg_wr[k]    = 1'b1;
                end
            end
            if (reg_addr == ADDR_W'(STAT_ADDR)) chan_clr = reg_wdata[NCHAN-1:0];
            for (int j = 0; j < NGRP; j++) begin
                if (reg_addr == ADDR_W'(GRP_BASE + 3 * j)) begin
                    st_d.gctl[j].and_mode  = reg_wdata[GCTL_AND];
                    st_d.gctl[j].edge_mode = reg_wdata[GCTL_EDGE];
                end
                if (reg_addr == ADDR_W'(GRP_BASE + 3 * j + 1)) st_d.gmask[j] = reg_wdata[NPINS-1:0];
                if (reg_addr == ADDR_W'(GRP_BASE + 3 * j + 2)) st_d.gpol[j]  = reg_wdata[NPINS-1:0];
            end
            if (reg_addr == ADDR_W'(GSTAT_ADDR)) grp_clr = reg_wdata[NGRP-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        reg_rdata = '0;
        for (int k = 0; k < NCHAN; k++)
            if (reg_addr == ADDR_W'(k)) reg_rdata = cfg_to_word(st_q.ccfg[k]);
        if (reg_addr == ADDR_W'(STAT_ADDR)) reg_rdata = 32'(chan_irq_o);
        for (int j = 0; j < NGRP; j++) begin
            if (reg_addr == ADDR_W'(GRP_BASE + 3 * j))
                reg_rdata = 32'({st_q.gctl[j].edge_mode, st_q.gctl[j].and_mode});
            if (reg_addr == ADDR_W'(GRP_BASE + 3 * j + 1)) reg_rdata = 32'(st_q.gmask[j]);
            if (reg_addr == ADDR_W'(GRP_BASE + 3 * j + 2)) reg_rdata = 32'(st_q.gpol[j]);
        end
        if (reg_addr == ADDR_W'(GSTAT_ADDR)) reg_rdata = 32'(grp_irq_o);
    end

    gpio_sync #(.W(NPINS)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw_i  (pins_i),
        .cur_o  (pin_cur),
        .prev_o (pin_prev)
    );

    for (genvar k = 0; k < NCHAN; k++) begin : g_chan
        gpio_pin_chan #(.NPINS(NPINS)) u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .cur_i    (pin_cur),
            .prev_i   (pin_prev),
            .cfg_i    (st_q.ccfg[k]),
            .cfg_wr_i (cfg_wr[k]),
            .clr_i    (chan_clr[k]),
            .irq_o    (chan_irq_o[k])
        );
    end

    for (genvar j = 0; j < NGRP; j++) begin : g_grp
        gpio_grp_match #(.NPINS(NPINS)) u_grp (
            .clk    (clk),
            .rst_n  (rst_n),
            .cur_i  (pin_cur),
            .mask_i (st_q.gmask[j]),
            .pol_i  (st_q.gpol[j]),
            .ctl_i  (st_q.gctl[j]),
            .clr_i  (grp_clr[j]),
            .irq_o  (grp_irq_o[j])
        );
    end
endmodule

// File: rtl/gpio_irq_unit_chk.sv
module gpio_irq_unit_chk
    import gpio_irq_pkg::*;
#(
    parameter int NPINS  = 32,
    parameter int NCHAN  = 8,
    parameter int NGRP   = 2,
    parameter int ADDR_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic [NPINS-1:0]  pins_i,
    input logic              reg_we,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [31:0]       reg_wdata,
    input logic [NCHAN-1:0]  chan_irq_o,
    input logic [NGRP-1:0]   grp_irq_o
);
    localparam int STAT_ADDR  = NCHAN;
    localparam int GRP_BASE   = NCHAN + 1;
    localparam int GSTAT_ADDR = GRP_BASE + 3 * NGRP;

    logic [NPINS-1:0] pins_last_q;
    logic [2:0]       quiet_q;
    logic [NCHAN-1:0] lvl_seen_q;
    logic [NGRP-1:0]  gedge_seen_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pins_last_q  <= '0;
            quiet_q      <= '0;
            lvl_seen_q   <= '0;
            gedge_seen_q <= '0;
        end else begin
            pins_last_q <= pins_i;
            if (pins_i == pins_last_q && !reg_we)
                quiet_q <= (quiet_q == 3'd7) ? 3'd7 : quiet_q + 3'd1;
            else
                quiet_q <= '0;
            for (int k = 0; k < NCHAN; k++)
                if (reg_we && reg_addr == ADDR_W'(k)) lvl_seen_q[k] <= reg_wdata[CFG_LVL_BIT];
            for (int j = 0; j < NGRP; j++)
                if (reg_we && reg_addr == ADDR_W'(GRP_BASE + 3 * j))
                    gedge_seen_q[j] <= reg_wdata[GCTL_EDGE];
        end
    end

    // R1
    reset_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (chan_irq_o == '0 && grp_irq_o == '0));

    // R11
    quiet_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        quiet_q >= 3'd4 |-> ($stable(chan_irq_o) && $stable(grp_irq_o)));

    for (genvar k = 0; k < NCHAN; k++) begin : g_ck
        // R6
        cfg_wipe_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (reg_we && reg_addr == ADDR_W'(k) && !reg_wdata[CFG_LVL_BIT]) |=> !chan_irq_o[k]);
        // R3
        chan_w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (quiet_q >= 3'd4 && reg_we && reg_addr == ADDR_W'(STAT_ADDR) &&
             reg_wdata[k] && !lvl_seen_q[k]) |=> !chan_irq_o[k]);
    end

    for (genvar j = 0; j < NGRP; j++) begin : g_gk
        // R10
        grp_w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (quiet_q >= 3'd4 && reg_we && reg_addr == ADDR_W'(GSTAT_ADDR) &&
             reg_wdata[j] && gedge_seen_q[j]) |=> !grp_irq_o[j]);
    end
endmodule

bind gpio_irq_unit gpio_irq_unit_chk #(
    .NPINS(NPINS), .NCHAN(NCHAN), .NGRP(NGRP), .ADDR_W(ADDR_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .pins_i     (pins_i),
    .reg_we     (reg_we),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .chan_irq_o (chan_irq_o),
    .grp_irq_o  (grp_irq_o)
);

// File: tb/gpio_irq_unit_bench.sv
module gpio_irq_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] pins = '0;
    logic        reg_we = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [7:0]  chan_irq;
    logic [1:0]  grp_irq;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #5 clk = ~clk;

    gpio_irq_unit u_gpio_irq_unit (
        .clk        (clk),
        .rst_n      (rst_n),
        .pins_i     (pins),
        .reg_we     (reg_we),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .chan_irq_o (chan_irq),
        .grp_irq_o  (grp_irq)
    );

    typedef struct packed {
        logic [7:0]  chan;
        logic [1:0]  grp;
        logic        rd_chk;
        logic [31:0] rd;
    } item_t;

    item_t item_q[$];
    string tag_q[$];
    item_t it;
    string tg;

    // monitor: pops expected items and compares, 2 ns after the falling edge
    always @(negedge clk) begin
        #2;
        while (item_q.size() > 0) begin
            it = item_q.pop_front();
            tg = tag_q.pop_front();
            total++;
            if (chan_irq !== it.chan || grp_irq !== it.grp ||
                (it.rd_chk && reg_rdata !== it.rd)) begin
                bad++;
                $display("FAIL %s: chan=%h grp=%b rd=%h expected chan=%h grp=%b rd=%h",
                         tg, chan_irq, grp_irq, reg_rdata, it.chan, it.grp, it.rd);
            end
        end
    end

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0; reg_wdata = '0;
    endtask

    task automatic set_pins(input logic [31:0] v);
        @(negedge clk);
        pins = v;
    endtask

    task automatic push(input string tag, input logic [7:0] c, input logic [1:0] g,
                        input logic rc, input logic [3:0] ra, input logic [31:0] rd);
        item_t n;
        reg_addr = ra;
        n.chan = c; n.grp = g; n.rd_chk = rc; n.rd = rd;
        item_q.push_back(n);
        tag_q.push_back(tag);
    endtask

    task automatic expect_out(input string tag, input logic [7:0] c, input logic [1:0] g,
                              input logic rc, input logic [3:0] ra, input logic [31:0] rd);
        repeat (6) @(negedge clk);
        push(tag, c, g, rc, ra, rd);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        expect_out("R1 reset outputs and status", 8'h00, 2'b00, 1, 4'd8, 32'h0);
        expect_out("R1 reset config reads zero", 8'h00, 2'b00, 1, 4'd3, 32'h0);

        // channel 0: pin 5, edge, rising
        wr(4'd0, 32'd5 | (32'd1 << 9));
        expect_out("R2 config readback", 8'h00, 2'b00, 1, 4'd0, 32'h205);
        set_pins(pins | 32'h20);
        expect_out("R2 R3 rising edge on pin 5", 8'h01, 2'b00, 1, 4'd8, 32'h1);
        set_pins(pins & ~32'h20);
        expect_out("R3 status held after pin falls", 8'h01, 2'b00, 0, 4'd0, 32'h0);
        wr(4'd8, 32'h0);
        expect_out("R7 zero write keeps status", 8'h01, 2'b00, 0, 4'd0, 32'h0);
        wr(4'd8, 32'hFE);
        expect_out("R7 other bits keep status", 8'h01, 2'b00, 0, 4'd0, 32'h0);
        wr(4'd8, 32'h1);
        expect_out("R3 write one clears", 8'h00, 2'b00, 1, 4'd8, 32'h0);

        // channel 3: pin 31, edge, falling
        wr(4'd3, 32'd31 | (32'd1 << 10));
        set_pins(pins | 32'h8000_0000);
        expect_out("R4 rising ignored when only falling enabled", 8'h00, 2'b00, 0, 4'd0, 32'h0);
        set_pins(pins & ~32'h8000_0000);
        expect_out("R4 falling edge on pin 31", 8'h08, 2'b00, 0, 4'd0, 32'h0);
        wr(4'd3, 32'd31 | (32'd1 << 10));
        expect_out("R6 config write clears pending", 8'h00, 2'b00, 0, 4'd0, 32'h0);

        // channel 7: pin 0, level high
        wr(4'd7, (32'd1 << 8) | (32'd1 << 9));
        expect_out("R5 level high inactive", 8'h00, 2'b00, 0, 4'd0, 32'h0);
        @(negedge clk);
        pins = pins | 32'h1;
        @(negedge clk);
        push("R11 one edge after pin change", 8'h00, 2'b00, 0, 4'd0, 32'h0);
        @(negedge clk);
        push("R11 R5 two edges after pin change", 8'h80, 2'b00, 0, 4'd0, 32'h0);
        set_pins(pins & ~32'h1);
        expect_out("R5 level request drops", 8'h00, 2'b00, 0, 4'd0, 32'h0);
        wr(4'd7, (32'd1 << 8) | (32'd1 << 10));
        expect_out("R5 level low active", 8'h80, 2'b00, 0, 4'd0, 32'h0);
        set_pins(pins | 32'h1);
        expect_out("R5 level low released", 8'h00, 2'b00, 0, 4'd0, 32'h0);
        wr(4'd7, 32'h0);

        // group 0, AND mode on pins 11..8 with pattern 1010
        wr(4'd10, 32'h0000_0F00);
        wr(4'd11, 32'h0000_0A00);
        wr(4'd9, 32'h1);
        set_pins(pins | 32'h0000_0A00);
        expect_out("R8 AND pattern matched", 8'h00, 2'b01, 1, 4'd9, 32'h1);
        set_pins(pins | 32'h0000_0100);
        expect_out("R8 AND one pin off", 8'h00, 2'b00, 0, 4'd0, 32'h0);
        wr(4'd10, 32'h0);
        set_pins(pins & ~32'h0000_0100);
        expect_out("R8 empty mask never matches", 8'h00, 2'b00, 0, 4'd0, 32'h0);

        // group 1, OR mode on pins 17,16: match if pin16=1 or pin17=0
        wr(4'd13, 32'h0003_0000);
        wr(4'd14, 32'h0001_0000);
        expect_out("R9 OR one pin agrees", 8'h00, 2'b10, 0, 4'd0, 32'h0);
        set_pins(pins | 32'h0002_0000);
        expect_out("R9 OR no pin agrees", 8'h00, 2'b00, 0, 4'd0, 32'h0);
        set_pins(pins | 32'h0001_0000);
        expect_out("R9 OR other pin agrees", 8'h00, 2'b10, 0, 4'd0, 32'h0);
        wr(4'd13, 32'h0);

        // group 0, AND with edge reporting
        set_pins(pins & ~32'h0000_0F00);
        wr(4'd10, 32'h0000_0F00);
        wr(4'd9, 32'h3);
        expect_out("R10 edge group idle", 8'h00, 2'b00, 0, 4'd0, 32'h0);
        set_pins(pins | 32'h0000_0A00);
        expect_out("R10 flag on entering match", 8'h00, 2'b01, 1, 4'd15, 32'h1);
        set_pins(pins & ~32'h0000_0F00);
        expect_out("R10 flag held after match ends", 8'h00, 2'b01, 0, 4'd0, 32'h0);
        wr(4'd15, 32'h1);
        expect_out("R10 flag cleared by write one", 8'h00, 2'b00, 1, 4'd15, 32'h0);

        repeat (4) @(negedge clk);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: run did not finish, actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule